// File: doc/BRIEF.md
# MMU Fault Status Recorder

This block keeps the fault record for one address translation unit, on either the instruction or the data side. When the translation logic finds a fault, it pulses a strobe and presents the fault's details: whether the access was a write, the context class, whether the page has side effects, a fault code and the address space identifier. The block packs these fields into a status word at fixed bit positions. The valid and overflow flags in that word show whether an earlier fault was still pending and had not been cleared.

A separate miss strobe loads a tag register from the faulting virtual address and the current context. With `HAS_FAR` set, each fault also loads the faulting virtual address into a fault address register. Software can load any of the three registers through a write port and can read them through a selectable read port.

The low two bits of the status word are held by a three-state machine. `ST_CLEAR` means no fault is pending. `ST_VALID` means one fault is recorded. `ST_OVER` means a fault arrived while another was still pending. The transitions are:
- `ST_CLEAR` goes to `ST_VALID` on a fault.
- `ST_VALID` goes to `ST_OVER` on a fault.
- `ST_OVER` stays in `ST_OVER` on a fault.
- A software load of the status register moves to the state its low bits select.
- With no fault and no software load, the state holds.

Top module: `mmu_fault_recorder`

## Requirements
- R1: After reset, the status, tag and fault address registers all read zero.
- R2: A fault strobe while status bit 0 is clear sets status bits 1:0 to 01.
- R3: A fault strobe while status bit 0 is set sets status bits 1:0 to 11, including when bit 1 was already set.
- R4: A fault strobe places its fields in the status word as follows:
  - write flag in bit 2;
  - context class in bits 5:4 (0 primary, 1 secondary, 2 nucleus);
  - side-effect flag in bit 6;
  - fault code in bits 13:7;
  - address space identifier in bits 23:16.
  Bit 3, bits 15:14 and bits 63:24 read zero.
- R5: A miss strobe loads the tag register with virtual address bits 63:13 and the 13-bit miss context in bits 12:0. A miss alone leaves the status word unchanged.
- R6: A fault strobe loads the fault address register with the full 64-bit virtual address.
- R7: A software write to the status register (select 0) keeps only the field bits listed in R4. Data bits 1:0 set the state as follows:
  - 00 or 10 clears;
  - 01 sets valid;
  - 11 sets valid and overflow.
- R8: A software write with select 1 loads the tag register, and one with select 2 loads the fault address register, each with the 64-bit data unchanged.
- R9: A hardware event in the same cycle as a software write wins. This applies to a fault against a status or fault address write, and to a miss against a tag write.
- R10: The read port is combinational and returns:
  - the status word for select 0;
  - the tag for select 1;
  - the fault address for select 2;
  - zero for select 3.
- R11: With no strobe and no software write to it, each register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_stb | input | 1 | Record a fault this cycle |
| flt_write | input | 1 | Faulting access was a write |
| flt_ctx | input | 2 | Context class of the fault |
| flt_side_eff | input | 1 | Faulting page has side effects |
| flt_code | input | 7 | Fault type code |
| flt_asi | input | 8 | Address space identifier |
| flt_va | input | 64 | Faulting virtual address |
| miss_stb | input | 1 | Record a translation miss this cycle |
| miss_ctx | input | 13 | Context number for the tag |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_sel | input | 2 | Software write target (0 status, 1 tag, 2 address) |
| sw_wr_data | input | 64 | Software write data |
| rd_sel | input | 2 | Read select |
| rd_data | output | 64 | Selected register value |

## Verification
The hardest cases to reach are the collisions: a software load and a hardware event landing on the same register in the same cycle, and a fault arriving while the machine is already in `ST_OVER`. Directed sequences set up these cases explicitly:
- three faults back to back, to reach and then stay in the overflow state;
- software loads with each low-bit pattern;
- software writes issued in the same cycle as fault and miss strobes.

A long stretch of random strobes and writes then follows. Throughout, a behavioural model is compared with every register through the read port after each clock.

// File: rtl/mmu_fsr_pkg.sv
package mmu_fsr_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_VALID = 2'd1,
        ST_OVER  = 2'd2
    } fsr_state_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_TAG    = 2'd1,
        SEL_ADDR   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam logic [1:0] CTX_PRIMARY   = 2'd0;
    localparam logic [1:0] CTX_SECONDARY = 2'd1;
    localparam logic [1:0] CTX_NUCLEUS   = 2'd2;

    localparam int WR_BIT   = 2;
    localparam int CTX_LSB  = 4;
    localparam int SIDE_BIT = 6;
    localparam int CODE_LSB = 7;
    localparam int ASI_LSB  = 16;

endpackage

// File: rtl/mmu_fsr_state_fsm.sv
module mmu_fsr_state_fsm
    import mmu_fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_stb,
    input  logic       sw_ld,
    input  logic [1:0] sw_low,
    output logic [1:0] low_bits
);

    fsr_state_e state_q;
    fsr_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (fault_stb) begin
            unique case (state_q)
                ST_CLEAR: state_d = ST_VALID;
                ST_VALID: state_d = ST_OVER;
                ST_OVER:  state_d = ST_OVER;
                default:  state_d = ST_CLEAR;
            endcase
        end else if (sw_ld) begin
            unique case (sw_low)
                2'b01:   state_d = ST_VALID;
                2'b11:   state_d = ST_OVER;
                default: state_d = ST_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_VALID: low_bits = 2'b01;
            ST_OVER:  low_bits = 2'b11;
            default:  low_bits = 2'b00;
        endcase
    end

endmodule

// File: rtl/mmu_fsr_fields.sv
module mmu_fsr_fields
    import mmu_fsr_pkg::*;
#(
    parameter int FT_W  = 7,
    parameter int ASI_W = 8,
    localparam int SR_W = ASI_LSB + ASI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_stb,
    input  logic             flt_write,
    input  logic [1:0]       flt_ctx,
    input  logic             flt_side_eff,
    input  logic [FT_W-1:0]  flt_code,
    input  logic [ASI_W-1:0] flt_asi,
    input  logic             sw_ld,
    input  logic [SR_W-1:0]  sw_data,
    output logic [SR_W-1:0]  fields_q
);

    logic [SR_W-1:0] fault_word;
    logic [SR_W-1:0] sw_word;

    always_comb begin
        fault_word                   = '0;
        fault_word[WR_BIT]           = flt_write;
        fault_word[CTX_LSB +: 2]     = flt_ctx;
        fault_word[SIDE_BIT]         = flt_side_eff;
        fault_word[CODE_LSB +: FT_W] = flt_code;
        fault_word[ASI_LSB +: ASI_W] = flt_asi;
    end

    always_comb begin
        sw_word                   = '0;
        sw_word[WR_BIT]           = sw_data[WR_BIT];
        sw_word[CTX_LSB +: 2]     = sw_data[CTX_LSB +: 2];
        sw_word[SIDE_BIT]         = sw_data[SIDE_BIT];
        sw_word[CODE_LSB +: FT_W] = sw_data[CODE_LSB +: FT_W];
        sw_word[ASI_LSB +: ASI_W] = sw_data[ASI_LSB +: ASI_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         fields_q <= '0;
        else if (fault_stb) fields_q <= fault_word;
        else if (sw_ld)     fields_q <= sw_word;
    end

endmodule

// File: rtl/mmu_fsr_ldreg.sv
module mmu_fsr_ldreg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hw_ld,
    input  logic [W-1:0] hw_val,
    input  logic         sw_ld,
    input  logic [W-1:0] sw_val,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (hw_ld) q <= hw_val;
        else if (sw_ld) q <= sw_val;
    end

endmodule

// File: rtl/mmu_fault_recorder.sv
module mmu_fault_recorder
    import mmu_fsr_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PG_SHIFT = 13,
    parameter int CTX_W    = 13,
    parameter int FT_W     = 7,
    parameter int ASI_W    = 8,
    parameter bit HAS_FAR  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_stb,
    input  logic             flt_write,
    input  logic [1:0]       flt_ctx,
    input  logic             flt_side_eff,
    input  logic [FT_W-1:0]  flt_code,
    input  logic [ASI_W-1:0] flt_asi,
    input  logic [VA_W-1:0]  flt_va,
    input  logic             miss_stb,
    input  logic [CTX_W-1:0] miss_ctx,
    input  logic             sw_wr_en,
    input  logic [1:0]       sw_wr_sel,
    input  logic [VA_W-1:0]  sw_wr_data,
    input  logic [1:0]       rd_sel,
    output logic [VA_W-1:0]  rd_data
);

    localparam int SR_W = ASI_LSB + ASI_W;

    logic            sw_status_ld;
    logic            sw_tag_ld;
    logic            sw_addr_ld;
    logic [1:0]      low_bits;
    logic [SR_W-1:0] fields_q;
    logic [SR_W-1:0] status_word;
    logic [VA_W-1:0] tag_hw;
    logic [VA_W-1:0] tag_q;
    logic [VA_W-1:0] far_q;

    assign sw_status_ld = sw_wr_en && (sw_wr_sel == SEL_STATUS);
    assign sw_tag_ld    = sw_wr_en && (sw_wr_sel == SEL_TAG);
    assign sw_addr_ld   = sw_wr_en && (sw_wr_sel == SEL_ADDR);

    mmu_fsr_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_stb(fault_stb),
        .sw_ld    (sw_status_ld),
        .sw_low   (sw_wr_data[1:0]),
        .low_bits (low_bits)
    );

    mmu_fsr_fields #(.FT_W(FT_W), .ASI_W(ASI_W)) u_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_stb   (fault_stb),
        .flt_write   (flt_write),
        .flt_ctx     (flt_ctx),
        .flt_side_eff(flt_side_eff),
        .flt_code    (flt_code),
        .flt_asi     (flt_asi),
        .sw_ld       (sw_status_ld),
        .sw_data     (sw_wr_data[SR_W-1:0]),
        .fields_q    (fields_q)
    );

    assign status_word = {fields_q[SR_W-1:2], low_bits};

    assign tag_hw = {flt_va[VA_W-1:PG_SHIFT], PG_SHIFT'(miss_ctx)};

    mmu_fsr_ldreg #(.W(VA_W)) u_tag (
        .clk   (clk),
        .rst_n (rst_n),
        .hw_ld (miss_stb),
        .hw_val(tag_hw),
        .sw_ld (sw_tag_ld),
        .sw_val(sw_wr_data),
        .q     (tag_q)
    );

    generate
        if (HAS_FAR) begin : g_far
            mmu_fsr_ldreg #(.W(VA_W)) u_far (
                .clk   (clk),
                .rst_n (rst_n),
                .hw_ld (fault_stb),
                .hw_val(flt_va),
                .sw_ld (sw_addr_ld),
                .sw_val(sw_wr_data),
                .q     (far_q)
            );
        end else begin : g_no_far
            assign far_q = '0;
        end
    endgenerate

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_STATUS: rd_data = VA_W'(status_word);
            SEL_TAG:    rd_data = tag_q;
            SEL_ADDR:   rd_data = far_q;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mmu_fsr_chk.sv
module mmu_fsr_chk #(
    parameter int VA_W     = 64,
    parameter int PG_SHIFT = 13,
    parameter int CTX_W    = 13,
    parameter int FT_W     = 7,
    parameter int ASI_W    = 8,
    parameter bit HAS_FAR  = 1'b1,
    localparam int SR_W    = 16 + ASI_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fault_stb,
    input logic             flt_write,
    input logic [1:0]       flt_ctx,
    input logic             flt_side_eff,
    input logic [FT_W-1:0]  flt_code,
    input logic [ASI_W-1:0] flt_asi,
    input logic [VA_W-1:0]  flt_va,
    input logic             miss_stb,
    input logic [CTX_W-1:0] miss_ctx,
    input logic             sw_wr_en,
    input logic [1:0]       sw_wr_sel,
    input logic [1:0]       sw_low,
    input logic [SR_W-1:0]  status_word,
    input logic [VA_W-1:0]  tag_q,
    input logic [VA_W-1:0]  far_q
);

    // R2
    fault_from_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb && !status_word[0] |=> status_word[1:0] == 2'b01);

    // R3
    fault_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb && status_word[0] |=> status_word[1:0] == 2'b11);

    // R4
    fault_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb |=> status_word[2] == $past(flt_write)
                   && status_word[5:4] == $past(flt_ctx)
                   && status_word[6] == $past(flt_side_eff)
                   && status_word[7 +: FT_W] == $past(flt_code)
                   && status_word[16 +: ASI_W] == $past(flt_asi));

    // R5
    tag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stb |=> tag_q[VA_W-1:PG_SHIFT] == $past(flt_va[VA_W-1:PG_SHIFT])
                  && tag_q[PG_SHIFT-1:0] == PG_SHIFT'($past(miss_ctx)));

    // R9
    fault_beats_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb && sw_wr_en && sw_wr_sel == 2'd0 && sw_low == 2'b00
        |=> status_word[0]);

    // R7
    sw_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_stb && sw_wr_en && sw_wr_sel == 2'd0
        |=> status_word[0] == $past(sw_low[0])
         && status_word[1] == $past(sw_low[0] & sw_low[1]));

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_stb && !(sw_wr_en && sw_wr_sel == 2'd0) |=> $stable(status_word));

    generate
        if (HAS_FAR) begin : g_far_chk
            // R6
            far_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fault_stb |=> far_q == $past(flt_va));
        end
    endgenerate

endmodule

bind mmu_fault_recorder mmu_fsr_chk #(
    .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .CTX_W(CTX_W),
    .FT_W(FT_W), .ASI_W(ASI_W), .HAS_FAR(HAS_FAR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_stb   (fault_stb),
    .flt_write   (flt_write),
    .flt_ctx     (flt_ctx),
    .flt_side_eff(flt_side_eff),
    .flt_code    (flt_code),
    .flt_asi     (flt_asi),
    .flt_va      (flt_va),
    .miss_stb    (miss_stb),
    .miss_ctx    (miss_ctx),
    .sw_wr_en    (sw_wr_en),
    .sw_wr_sel   (sw_wr_sel),
    .sw_low      (sw_wr_data[1:0]),
    .status_word (status_word),
    .tag_q       (tag_q),
    .far_q       (far_q)
);

// File: tb/mmu_fault_recorder_tb.sv
`timescale 1ns/1ps
module mmu_fault_recorder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fault_stb;
    logic        flt_write;
    logic [1:0]  flt_ctx;
    logic        flt_side_eff;
    logic [6:0]  flt_code;
    logic [7:0]  flt_asi;
    logic [63:0] flt_va;
    logic        miss_stb;
    logic [12:0] miss_ctx;
    logic        sw_wr_en;
    logic [1:0]  sw_wr_sel;
    logic [63:0] sw_wr_data;
    logic [1:0]  rd_sel;
    logic [63:0] rd_data;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit          m_valid, m_ovf;
    logic [63:0] m_fields, m_tag, m_far;
    localparam logic [63:0] FIELD_MASK = 64'h0000_0000_00FF_3FF4;

    always #10 clk = ~clk;

    mmu_fault_recorder dut_i (
        .clk(clk), .rst_n(rst_n), .fault_stb(fault_stb), .flt_write(flt_write),
        .flt_ctx(flt_ctx), .flt_side_eff(flt_side_eff), .flt_code(flt_code),
        .flt_asi(flt_asi), .flt_va(flt_va), .miss_stb(miss_stb), .miss_ctx(miss_ctx),
        .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [63:0] expect_rd(input int sel);
        case (sel)
            0: return m_fields | {62'd0, m_ovf, m_valid};
            1: return m_tag;
            2: return m_far;
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fault_stb = 0; flt_write = 0; flt_ctx = 0; flt_side_eff = 0;
        flt_code = 0; flt_asi = 0; flt_va = 0; miss_stb = 0; miss_ctx = 0;
        sw_wr_en = 0; sw_wr_sel = 0; sw_wr_data = 0;
    endtask

    // one clock: model advances from the inputs, then all registers are compared
    task automatic cycle(input string tag);
        bit          n_valid = m_valid, n_ovf = m_ovf;
        logic [63:0] n_fields = m_fields, n_tag = m_tag, n_far = m_far;
        if (fault_stb) begin
            n_ovf    = m_valid;
            n_valid  = 1;
            n_fields = (64'(flt_write) << 2) | (64'(flt_ctx) << 4) |
                       (64'(flt_side_eff) << 6) | (64'(flt_code) << 7) |
                       (64'(flt_asi) << 16);
            n_far    = flt_va;
        end else if (sw_wr_en && sw_wr_sel == 0) begin
            n_valid  = sw_wr_data[0];
            n_ovf    = sw_wr_data[0] & sw_wr_data[1];
            n_fields = sw_wr_data & FIELD_MASK;
        end
        if (!fault_stb && sw_wr_en && sw_wr_sel == 2) n_far = sw_wr_data;
        if (miss_stb) n_tag = (flt_va & ~64'h1FFF) | 64'(miss_ctx);
        else if (sw_wr_en && sw_wr_sel == 1) n_tag = sw_wr_data;
        @(posedge clk);
        #2;
        m_valid = n_valid; m_ovf = n_ovf; m_fields = n_fields;
        m_tag = n_tag; m_far = n_far;
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            check($sformatf("%s sel%0d", tag, s), rd_data, expect_rd(s));
        end
        idle_inputs();
    endtask

    task automatic fault(input bit w, input logic [1:0] c, input bit se,
                         input logic [6:0] code, input logic [7:0] asi, input logic [63:0] va);
        fault_stb = 1; flt_write = w; flt_ctx = c; flt_side_eff = se;
        flt_code = code; flt_asi = asi; flt_va = va;
    endtask

    task automatic sw(input logic [1:0] sel, input logic [63:0] d);
        sw_wr_en = 1; sw_wr_sel = sel; sw_wr_data = d;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rd_sel = 0;
        rst_n = 0;
        m_valid = 0; m_ovf = 0; m_fields = 0; m_tag = 0; m_far = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        cycle("R1 reset");

        // R2 first fault, R4 field placement
        fault(1, 2'd0, 0, 7'h55, 8'h80, 64'hDEAD_BEEF_0000_1234);
        cycle("R2 R4 first fault");
        check("R2 low bits", expect_rd(0) & 64'h3, 64'h1);
        // R3 second fault overflows
        fault(0, 2'd2, 1, 7'h7F, 8'hFF, 64'h1111_2222_3333_4444);
        cycle("R3 overflow");
        // R3 third fault stays overflowed
        fault(1, 2'd1, 0, 7'h01, 8'h04, 64'h8000_0000_0000_0008);
        cycle("R3 stay overflow");
        // R7 clear via software
        sw(0, 64'h0);
        cycle("R7 clear");
        repeat (2) cycle("R11 hold");
        // R5 miss, status untouched
        flt_va = 64'hFFFF_0000_ABCD_E5A5; miss_stb = 1; miss_ctx = 13'h1ABC;
        cycle("R5 miss");
        // R6 FAR capture on a fault from clear (R2)
        fault(0, 2'd1, 1, 7'h2A, 8'h14, 64'h0123_4567_89AB_CDEF);
        cycle("R6 R2 far");
        // R8 software tag and address writes
        sw(1, 64'hA5A5_5A5A_F0F0_0F0F);
        cycle("R8 tag write");
        sw(2, 64'h0F0F_F0F0_1234_5678);
        cycle("R8 addr write");
        // R7 masked write with overflow, then 10 pattern clears
        sw(0, 64'hFFFF_FFFF_FFFF_FFFF);
        cycle("R7 masked 11");
        sw(0, 64'h0000_0000_0000_0076);
        cycle("R7 low 10 clears");
        sw(0, 64'h0000_0000_0000_0001);
        cycle("R7 low 01");
        // R9 collisions
        fault(1, 2'd2, 0, 7'h33, 8'h99, 64'hCAFE_0000_0000_0010);
        sw(0, 64'h0);
        cycle("R9 fault beats status write");
        fault(0, 2'd0, 0, 7'h11, 8'h22, 64'h7777_0000_0000_2000);
        sw(2, 64'h1);
        cycle("R9 fault beats addr write");
        flt_va = 64'h5555_6666_7777_8888; miss_stb = 1; miss_ctx = 13'h0007;
        sw(1, 64'h0);
        cycle("R9 miss beats tag write");
        // R10 unused select stays zero across random traffic; R11 random mix
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 9);
            if (r < 2) fault(1'($urandom), 2'($urandom_range(0, 2)), 1'($urandom),
                             7'($urandom), 8'($urandom), {$urandom, $urandom});
            if (r == 3 || r == 4) begin
                flt_va = {$urandom, $urandom}; miss_stb = 1; miss_ctx = 13'($urandom);
            end
            if (r >= 5 && r <= 7) sw(2'($urandom_range(0, 3)), {$urandom, $urandom});
            cycle("R10 R11 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule